// File: doc/BRIEF.md
# Trap and Interrupt Vectoring Controller

This block chooses which trap a processor core takes in a given cycle and computes where execution continues. Each cycle it looks at a synchronous exception request, which carries a kind code and an 8-bit call-gate argument, and at four asynchronous interrupt lines: device, timer, inter-processor and machine check. When it accepts an event, it adds a fixed or computed handler offset to the privileged-code base register to form the new program counter. It also saves the interrupted PC with bit 0 replaced by the privileged-mode flag, and raises a one-cycle strobe that tells the core to enter privileged mode.

The core keeps ownership of the privileged-mode flag and the interrupt priority level (IPL). The controller reads both. When privileged mode is active, all interrupts are held off. The IPL masks the lower-ranked interrupt lines step by step. A synchronous request always wins over a pending interrupt.

Control is a two-state machine. `ST_IDLE` evaluates requests on every edge. The transition *accept* (`ST_IDLE` to `ST_ENTER`) happens on the edge where a valid event is present, and it registers the new PC and the saved address. `ST_ENTER` drives the taken pulse, ignores every request, and always makes the transition *resume* back to `ST_IDLE` on the next edge.

Top module: `trap_vector_unit`

## Requirements
- R1: While reset is asserted, `taken` and `priv_set` are low and `new_pc` and `exc_addr` are zero.
- R2: The sync kind code selects a fixed offset of code×0x80. The codes are: 0 reset, 1 machine check, 2 inter-processor, 3 timer, 4 device, 5 memory fault, 6 unaligned access, 7 illegal opcode, 8 arithmetic, 9 floating point disabled.
- R3: Kind code 10 is a call gate. If argument bit 7 is set, the offset is 0x2000 + (arg−0x80)×64. Otherwise the offset is 0x1000 + arg×64.
- R4: `new_pc` equals `pal_base` plus the selected offset, using the `pal_base` value at the accepting edge.
- R5: `exc_addr` equals `cur_pc` with bit 0 replaced by `priv_mode`, both sampled at the accepting edge.
- R6: After an accepting edge, `taken` and `priv_set` are high together for exactly one cycle. `new_pc` and `exc_addr` hold their values until the next accept.
- R7: No interrupt line is accepted while `priv_mode` is high.
- R8: Interrupt eligibility depends on the IPL:
  - At IPL 0–3, all four lines are eligible.
  - At IPL 4, device is masked.
  - At IPL 5, timer is also masked.
  - At IPL 6, only machine check remains.
  - At IPL 7, no line is eligible.
- R9: Among eligible lines the priority is machine check, then inter-processor, then timer, then device. The chosen line uses the offsets of kind codes 1, 2, 3 and 4 respectively.
- R10: A valid synchronous request is accepted instead of any pending interrupt in the same cycle.
- R11: Sync kind codes 11 to 15 count as no request. In that case only the interrupt lines decide.
- R12: Every request seen on the edge that ends the taken cycle is ignored. Requests are accepted at most every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | ADDR_W | PC of the instruction being interrupted |
| priv_mode | input | 1 | Core is in privileged mode |
| ipl | input | IPL_W | Current interrupt priority level |
| irq_device | input | 1 | Device interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ipi | input | 1 | Inter-processor interrupt line |
| irq_mcheck | input | 1 | Machine check line |
| pal_base | input | ADDR_W | Privileged-code base register |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Sync kind code (R2, R3, R11) |
| exc_arg | input | GATE_W | Call-gate argument |
| new_pc | output | ADDR_W | Handler entry address |
| exc_addr | output | ADDR_W | Saved return address with the mode bit |
| priv_set | output | 1 | Strobe that sets privileged mode |
| taken | output | 1 | One-cycle pulse for an accepted event |

## Verification
The assertions assume that `priv_mode` and `pal_base` come from registers of the core and are steady at each sampling edge. They also assume that every input is driven to a known value from reset onward. The bench changes every input only on the falling edge and keeps each request for exactly one sampling edge, except in the R12 case, where it holds a request on purpose. The sweeps cover:
- every IPL, mode and interrupt-line combination;
- all sixteen sync kind codes against fully pending interrupt lines;
- all 256 call-gate arguments.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        EV_RESET   = 4'd0,
        EV_MCHECK  = 4'd1,
        EV_IPI     = 4'd2,
        EV_TIMER   = 4'd3,
        EV_DEVICE  = 4'd4,
        EV_MEMFLT  = 4'd5,
        EV_UNALIGN = 4'd6,
        EV_ILLOP   = 4'd7,
        EV_ARITH   = 4'd8,
        EV_FPOFF   = 4'd9,
        EV_GATE    = 4'd10
    } ev_kind_t;

    localparam logic [KIND_W-1:0] LAST_KIND = 4'd10;

    typedef enum logic {
        ST_IDLE,
        ST_ENTER
    } trap_state_t;

endpackage

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
    import trap_vec_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int IPL_W    = 3,
    parameter int LOW_CEIL = 3
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [IPL_W-1:0]   ipl,
    input  logic               priv,
    output logic               hit,
    output logic [KIND_W-1:0]  kind
);

    // Line i (0 = device ... 3 = machine check) stays eligible up to IPL LOW_CEIL+i.
    logic [N_LINES-1:0] elig;
    logic [N_LINES-1:0] grant;

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_gate
            localparam int unsigned CEIL = LOW_CEIL + i;
            assign elig[i] = lines[i] & ~priv & (32'(ipl) <= CEIL);
        end
    endgenerate

    // The highest index wins: scan upward and let later hits override earlier ones.
    always_comb begin
        grant = '0;
        kind  = EV_DEVICE;
        for (int i = 0; i < N_LINES; i++) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                kind     = KIND_W'(int'(EV_DEVICE) - i);
            end
        end
    end

    assign hit = |grant;

    always_comb begin
        assert_one_grant_R9: assert ($onehot0(grant));
        assert_priv_gate_R7: assert (!(hit && priv));
    end

endmodule

// File: rtl/trap_vec_offset.sv
module trap_vec_offset
    import trap_vec_pkg::*;
#(
    parameter int GATE_W       = 8,
    parameter int OFF_W        = 14,
    parameter int FIXED_SHIFT  = 7,
    parameter int SLOT_SHIFT   = 6,
    parameter int GATE_LO_BASE = 32'h1000,
    parameter int GATE_HI_BASE = 32'h2000
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [GATE_W-1:0] gate_code,
    output logic [OFF_W-1:0]  offset
);

    localparam int IDX_W = GATE_W - 1;

    logic [IDX_W-1:0] slot_idx;
    logic             upper_bank;
    logic [OFF_W-1:0] slot_off;
    logic [OFF_W-1:0] bank_base;

    assign slot_idx   = gate_code[IDX_W-1:0];
    assign upper_bank = gate_code[GATE_W-1];
    assign slot_off   = OFF_W'(slot_idx) << SLOT_SHIFT;
    assign bank_base  = upper_bank ? OFF_W'(GATE_HI_BASE) : OFF_W'(GATE_LO_BASE);

    always_comb begin
        if (kind == EV_GATE) begin
            offset = bank_base + slot_off;
        end else begin
            offset = OFF_W'(kind) << FIXED_SHIFT;
        end
    end

    always_comb begin
        if (kind == EV_GATE) begin
            assert_gate_region_R3: assert (offset >= OFF_W'(GATE_LO_BASE)
                                           && offset[SLOT_SHIFT-1:0] == '0);
        end
    end

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
    import trap_vec_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IPL_W  = 3,
    parameter int GATE_W = 8,
    parameter int OFF_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              priv_mode,
    input  logic [IPL_W-1:0]  ipl,
    input  logic              irq_device,
    input  logic              irq_timer,
    input  logic              irq_ipi,
    input  logic              irq_mcheck,
    input  logic [ADDR_W-1:0] pal_base,
    input  logic              exc_req,
    input  logic [3:0]        exc_code,
    input  logic [GATE_W-1:0] exc_arg,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              priv_set,
    output logic              taken
);

    localparam int N_IRQ = 4;

    trap_state_t        state, state_nx;
    logic [N_IRQ-1:0]   irq_vec;
    logic               sync_ok;
    logic               irq_hit;
    logic [KIND_W-1:0]  irq_kind;
    logic [KIND_W-1:0]  sel_kind;
    logic               fire;
    logic               accept;
    logic [OFF_W-1:0]   offset;
    logic [ADDR_W-1:0]  target;
    logic [ADDR_W-1:0]  ret_addr;

    assign irq_vec = {irq_mcheck, irq_ipi, irq_timer, irq_device};
    assign sync_ok = exc_req && (exc_code <= LAST_KIND);

    trap_irq_arbiter #(
        .N_LINES (N_IRQ),
        .IPL_W   (IPL_W),
        .LOW_CEIL(3)
    ) u_arb (
        .lines(irq_vec),
        .ipl  (ipl),
        .priv (priv_mode),
        .hit  (irq_hit),
        .kind (irq_kind)
    );

    assign sel_kind = sync_ok ? exc_code : irq_kind;
    assign fire     = sync_ok | irq_hit;
    assign accept   = (state == ST_IDLE) && fire;

    trap_vec_offset #(
        .GATE_W(GATE_W),
        .OFF_W (OFF_W)
    ) u_off (
        .kind     (sel_kind),
        .gate_code(exc_arg),
        .offset   (offset)
    );

    assign target   = pal_base + ADDR_W'(offset);
    assign ret_addr = (cur_pc & ~ADDR_W'(1)) | ADDR_W'(priv_mode);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fire) state_nx = ST_ENTER;
            ST_ENTER: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            priv_set <= 1'b0;
            new_pc   <= '0;
            exc_addr <= '0;
        end else begin
            taken    <= accept;
            priv_set <= accept;
            if (accept) begin
                new_pc   <= target;
                exc_addr <= ret_addr;
            end
        end
    end

    // R6 and R12: a pulse is never followed directly by another one
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

    assert_pc_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> $stable(new_pc));

    assert_mode_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> exc_addr[0] == $past(priv_mode));

    assert_priv_blocks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> !($past(priv_mode) && !$past(sync_ok)));

    assert_slot_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ((new_pc - $past(pal_base)) & ADDR_W'(63)) == '0);

endmodule

// File: tb/test_trap_vector_unit.sv
`timescale 1ns/1ps
module test_trap_vector_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cur_pc, pal_base;
    logic        priv_mode;
    logic [2:0]  ipl;
    logic        irq_device, irq_timer, irq_ipi, irq_mcheck;
    logic        exc_req;
    logic [3:0]  exc_code;
    logic [7:0]  exc_arg;
    logic [63:0] new_pc, exc_addr;
    logic        priv_set, taken;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_pc = '0;

    always #2.5 clk = ~clk;

    trap_vector_unit i_trap_vector_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .priv_mode(priv_mode), .ipl(ipl),
        .irq_device(irq_device), .irq_timer(irq_timer), .irq_ipi(irq_ipi),
        .irq_mcheck(irq_mcheck), .pal_base(pal_base), .exc_req(exc_req),
        .exc_code(exc_code), .exc_arg(exc_arg), .new_pc(new_pc), .exc_addr(exc_addr),
        .priv_set(priv_set), .taken(taken)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_off(input int kind, input int arg);
        if (kind == 10) return (arg >= 128) ? 64'(8192 + (arg - 128) * 64) : 64'(4096 + arg * 64);
        return 64'(kind * 128);
    endfunction

    function automatic int irq_pick(input logic [3:0] l, input int lvl, input logic pv);
        if (pv) return -1;
        if (l[3] && lvl <= 6) return 1;
        if (l[2] && lvl <= 5) return 2;
        if (l[1] && lvl <= 4) return 3;
        if (l[0] && lvl <= 3) return 4;
        return -1;
    endfunction

    task automatic clear_req();
        exc_req = 0; exc_code = 0; exc_arg = 0;
        {irq_mcheck, irq_ipi, irq_timer, irq_device} = 4'b0;
    endtask

    // Inputs already driven at a falling edge; k = expected kind or -1
    task automatic run_case(input string tag, input int k, input int arg);
        logic [63:0] e_pc, e_ea;
        @(posedge clk); @(negedge clk);
        if (k >= 0) begin
            e_pc = pal_base + exp_off(k, arg);
            e_ea = (cur_pc & ~64'd1) | {63'd0, priv_mode};
            chk({tag, " R6 taken"}, {63'd0, taken}, 64'd1);
            chk({tag, " R6 priv_set"}, {63'd0, priv_set}, 64'd1);
            chk({tag, " R4 new_pc"}, new_pc, e_pc);
            chk({tag, " R5 exc_addr"}, exc_addr, e_ea);
            last_pc = e_pc;
        end else begin
            chk({tag, " no take"}, {63'd0, taken}, 64'd0);
            chk({tag, " R6 pc held"}, new_pc, last_pc);
        end
        clear_req();
        @(posedge clk); @(negedge clk);
        chk({tag, " R6 pulse end"}, {63'd0, taken}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cur_pc = 0; pal_base = 0; priv_mode = 0; ipl = 0;
        clear_req();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 taken", {63'd0, taken}, 64'd0);
        chk("R1 priv_set", {63'd0, priv_set}, 64'd0);
        chk("R1 new_pc", new_pc, 64'd0);
        chk("R1 exc_addr", exc_addr, 64'd0);
        rst_n = 1;

        // Interrupt sweep: every IPL, mode and line pattern (R7 R8 R9)
        for (int lv = 0; lv < 8; lv++) begin
            for (int pv = 0; pv < 2; pv++) begin
                for (int m = 0; m < 16; m++) begin
                    pal_base  = {$urandom(), $urandom()};
                    cur_pc    = {$urandom(), $urandom()};
                    ipl       = 3'(lv);
                    priv_mode = pv[0];
                    {irq_mcheck, irq_ipi, irq_timer, irq_device} = 4'(m);
                    run_case(pv[0] ? "R7" : "R8 R9", irq_pick(4'(m), lv, pv[0]), 0);
                end
            end
        end

        // Sync kinds against fully pending interrupts (R2 R10 R11)
        for (int c = 0; c < 16; c++) begin
            int a;
            int k;
            a = int'($urandom() % 256);
            pal_base  = {$urandom(), $urandom()};
            cur_pc    = {$urandom(), $urandom()};
            ipl       = 0;
            priv_mode = c[0];
            exc_req   = 1; exc_code = 4'(c); exc_arg = 8'(a);
            {irq_mcheck, irq_ipi, irq_timer, irq_device} = 4'hF;
            k = (c <= 10) ? c : (c[0] ? -1 : 1);
            run_case((c <= 10) ? "R2 R10" : "R11", k, a);
        end

        // Call-gate argument sweep (R3)
        for (int a = 0; a < 256; a++) begin
            pal_base  = {$urandom(), $urandom()};
            cur_pc    = {$urandom(), $urandom()};
            priv_mode = a[1];
            ipl       = 3'(a % 8);
            exc_req   = 1; exc_code = 4'd10; exc_arg = 8'(a);
            run_case("R3", 10, a);
        end

        // A held request is ignored in the taken cycle (R12)
        pal_base = 64'h0000_0040_0000_0000; cur_pc = 64'h1234; priv_mode = 0; ipl = 0;
        irq_mcheck = 1;
        @(posedge clk); @(negedge clk);
        chk("R12 first pulse", {63'd0, taken}, 64'd1);
        chk("R12 first pc", new_pc, 64'h0000_0040_0000_0080);
        pal_base = 64'h0000_0080_0000_0000;
        @(posedge clk); @(negedge clk);
        chk("R12 ignored edge", {63'd0, taken}, 64'd0);
        chk("R12 pc unchanged", new_pc, 64'h0000_0040_0000_0080);
        @(posedge clk); @(negedge clk);
        chk("R12 second pulse", {63'd0, taken}, 64'd1);
        chk("R12 second pc", new_pc, 64'h0000_0080_0000_0080);
        clear_req();
        @(posedge clk); @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule